// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block sits at the pixel-clock end of a camera input path. It samples a parallel video bus together with its frame sync, line sync and data-enable strobes. It decides which pixel cycles carry picture data and packs the accepted bytes into 16-bit words for the receive FIFO that follows it. Each sync input can be inverted on its own, and the frame sync can pass through a programmable deglitch filter. Line qualification uses either all three strobes or only data-enable and frame sync.

A frame closes in one of two ways. In the first, the frame sync drops. In the second, a programmed number of bytes has been taken. When a frame closes while half a word is still waiting, that byte is pushed out on its own. A separate strobe pulses after every N completed lines. When stalling is enabled, pixels that arrive while the FIFO reports full are dropped. Every configuration field is held in a shadow copy that is loaded only by an update pulse. A level `start` input gates capture.

Top module: `dvp_capture`

## Requirements
- R1: In 8-bit mode every two accepted bytes form one output word, and the first byte sits in bits [7:0]. `outValid` pulses for one cycle, two clock edges after the second byte is sampled.
- R2: In 16-bit mode each accepted pixel gives one output word, with `pixData[7:0]` in bits [7:0] and `pixData[15:8]` in bits [15:8].
- R3: With `cfgInvDe`, `cfgInvHsync` or `cfgInvVsync` set, the matching pin is active low. The inversion is applied before any qualification, filtering or edge detection.
- R4: With `cfgDeOnly` = 0, a pixel is taken only when DE, HSYNC and VSYNC are all active. With `cfgDeOnly` = 1, HSYNC is ignored and follows DE.
- R5: With the filter enabled at threshold T (0..7), the internal frame sync changes only after the pin has held the new level for T+2 consecutive samples, so a pulse of T+1 samples is rejected. With the filter off, the pin is used directly.
- R6: With `cfgVsEof` = 1, a falling edge of the internal frame sync gives a one-cycle `outEof`. If a lone byte is pending, it comes out in the same cycle with `outOneByte` = 1 and zero in bits [15:8].
- R7: With `cfgVsEof` = 0 and `cfgByteLen` non-zero, `outEof` rises together with the word that holds byte number `cfgByteLen`, flushed as a single byte if needed. The rest of that frame is ignored. A value of 0 never ends a frame.
- R8: With `cfgLineIntEn` set, `outLineInt` pulses on every `cfgLineNum`-th line end. A line end is a falling edge of HSYNC in full mode, or of DE in DE-only mode. The count restarts at each frame start and never fires for `cfgLineNum` = 0.
- R9: With `cfgStallEn` set, a pixel sampled while `fifoFull` is high is dropped. With it clear, `fifoFull` has no effect.
- R10: `cfgByteSwap` exchanges the two bytes of an output word. `cfgBitRev` mirrors the bit order inside each byte.
- R11: Configuration inputs take effect only after a `cfgUpdate` pulse. No data is taken while `start` is low.
- R12: A `fifoReset` pulse discards a pending lone byte, so the next two bytes form a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture enable level |
| cfgUpdate | input | 1 | One-cycle pulse that loads the configuration shadow |
| softReset | input | 1 | One-cycle synchronous reset of all capture state |
| fifoReset | input | 1 | One-cycle pulse that drops a pending byte |
| cfgWide16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfgInvDe | input | 1 | Invert DE pin |
| cfgInvHsync | input | 1 | Invert HSYNC pin |
| cfgInvVsync | input | 1 | Invert VSYNC pin |
| cfgVsFiltEn | input | 1 | Enable frame sync deglitch |
| cfgVsFiltThr | input | 3 | Deglitch threshold |
| cfgDeOnly | input | 1 | Qualify lines by DE alone |
| cfgVsEof | input | 1 | 1 = end frame on sync fall, 0 = on byte count |
| cfgByteLen | input | 16 | Bytes per frame in count mode |
| cfgLineIntEn | input | 1 | Enable line strobe |
| cfgLineNum | input | 6 | Lines per line strobe |
| cfgStallEn | input | 1 | Drop pixels while FIFO full |
| cfgByteSwap | input | 1 | Swap bytes of each output word |
| cfgBitRev | input | 1 | Reverse bit order of each byte |
| pixData | input | 16 | Pixel data bus |
| vsyncIn | input | 1 | Frame sync pin |
| hsyncIn | input | 1 | Line sync pin |
| deIn | input | 1 | Data enable pin |
| fifoFull | input | 1 | Downstream FIFO full |
| outValid | output | 1 | Output word valid |
| outWord | output | 16 | Packed output word |
| outOneByte | output | 1 | Only bits [7:0] are meaningful |
| outEof | output | 1 | End of frame strobe |
| outLineInt | output | 1 | Line count strobe |

## Verification
A packer that loses or duplicates its pending byte shows up at once as a wrong pairing in the next word, or as a missing or extra `outOneByte` flush at frame end. A stale line or byte counter does its damage later: the line strobe or `outEof` fires a frame too early or too late. The directed scenarios therefore cross frame boundaries. A deglitch counter off by one changes whether a pulse of exactly T+1 or T+2 samples closes the frame, and that is visible on `outEof` within a few cycles.

// File: rtl/dvpc_pkg.sv
package dvpc_pkg;
  parameter int BYTE_W = 8;
  localparam int BUS_W = 2 * BYTE_W;
  parameter int CNT_W = 16;
  parameter int LINE_W = 6;
  parameter int THR_W = 3;

  typedef struct packed {
    logic              wide16;
    logic              invDe;
    logic              invHs;
    logic              invVs;
    logic              vsFiltEn;
    logic [THR_W-1:0]  vsFiltThr;
    logic              deOnly;
    logic              vsEof;
    logic [CNT_W-1:0]  byteLen;
    logic              lineIntEn;
    logic [LINE_W-1:0] lineNum;
    logic              stallEn;
    logic              byteSwap;
    logic              bitRev;
  } dvpc_cfg_t;

  typedef struct packed {
    logic take;
    logic eof;
    logic lineInt;
    logic clearPend;
  } dvpc_stb_t;
endpackage

// File: rtl/dvpc_ctrl.sv
module dvpc_ctrl
  import dvpc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cfgUpdate,
  input  logic      softReset,
  input  logic      fifoReset,
  input  dvpc_cfg_t cfgIn,
  input  logic      vsyncIn,
  input  logic      hsyncIn,
  input  logic      deIn,
  input  logic      fifoFull,
  output dvpc_cfg_t cfg,
  output dvpc_stb_t stb
);
  localparam int FCNT_W = THR_W + 1;

  logic sVs, sHs, sDe, sFull;
  logic filtReg;
  logic [FCNT_W-1:0] filtCnt;
  logic prevVs, prevLine, countDone;
  logic [CNT_W-1:0] byteCnt;
  logic [LINE_W-1:0] lineCnt;

  logic vsEff, lineSig, qual, frameStart, frameEnd, stall, doneEff, take;
  logic [CNT_W:0] incVal, newCnt;
  logic cntEof, vsEofHit, lineFall, lineHit;
  logic [LINE_W-1:0] baseLine, nextLine;

  // configuration shadow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (cfgUpdate) cfg <= cfgIn;
  end

  // input sampling with polarity applied first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sVs <= 1'b0; sHs <= 1'b0; sDe <= 1'b0; sFull <= 1'b0;
    end else if (softReset) begin
      sVs <= 1'b0; sHs <= 1'b0; sDe <= 1'b0; sFull <= 1'b0;
    end else begin
      sVs   <= vsyncIn ^ cfg.invVs;
      sHs   <= hsyncIn ^ cfg.invHs;
      sDe   <= deIn ^ cfg.invDe;
      sFull <= fifoFull;
    end
  end

  // frame sync deglitch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtReg <= 1'b0; filtCnt <= '0;
    end else if (softReset) begin
      filtReg <= 1'b0; filtCnt <= '0;
    end else if (!cfg.vsFiltEn) begin
      filtReg <= sVs; filtCnt <= '0;
    end else if (sVs == filtReg) begin
      filtCnt <= '0;
    end else if (filtCnt == FCNT_W'({1'b0, cfg.vsFiltThr}) + FCNT_W'(1)) begin
      filtReg <= sVs; filtCnt <= '0;
    end else begin
      filtCnt <= filtCnt + FCNT_W'(1);
    end
  end

  always_comb begin
    vsEff      = cfg.vsFiltEn ? filtReg : sVs;
    lineSig    = cfg.deOnly ? sDe : sHs;
    qual       = vsEff & sDe & lineSig;
    frameStart = start & vsEff & ~prevVs;
    frameEnd   = start & ~vsEff & prevVs;
    stall      = cfg.stallEn & sFull;
    doneEff    = frameStart ? 1'b0 : countDone;
    take       = start & qual & ~stall & ~doneEff;
    incVal     = cfg.wide16 ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
    newCnt     = (frameStart ? '0 : {1'b0, byteCnt}) + incVal;
    cntEof     = take & ~cfg.vsEof & (cfg.byteLen != '0) & (newCnt >= {1'b0, cfg.byteLen});
    vsEofHit   = cfg.vsEof & frameEnd;
    lineFall   = start & vsEff & prevLine & ~lineSig;
    baseLine   = frameStart ? '0 : lineCnt;
    nextLine   = baseLine + LINE_W'(1);
    lineHit    = lineFall & cfg.lineIntEn & (cfg.lineNum != '0) & (nextLine == cfg.lineNum);
    stb.take      = take;
    stb.eof       = cntEof | vsEofHit;
    stb.lineInt   = lineHit;
    stb.clearPend = frameStart | fifoReset | cfgUpdate | softReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevVs <= 1'b0; prevLine <= 1'b0; countDone <= 1'b0;
      byteCnt <= '0; lineCnt <= '0;
    end else if (softReset) begin
      prevVs <= 1'b0; prevLine <= 1'b0; countDone <= 1'b0;
      byteCnt <= '0; lineCnt <= '0;
    end else begin
      prevVs   <= vsEff;
      prevLine <= lineSig;
      if (take) byteCnt <= newCnt[CNT_W-1:0];
      else if (frameStart) byteCnt <= '0;
      if (cntEof) countDone <= 1'b1;
      else if (frameStart || cfgUpdate) countDone <= 1'b0;
      if (lineHit) lineCnt <= '0;
      else if (lineFall) lineCnt <= nextLine;
      else if (frameStart) lineCnt <= '0;
    end
  end

  // R5: the filtered sync only moves after the full hold count
  p_filter_hold_r5: assert property (@(posedge clk) disable iff (!rstN || softReset)
    ($past(cfg.vsFiltEn) && !$past(softReset) && (filtReg != $past(filtReg)))
      |-> ($past(filtCnt) == FCNT_W'({1'b0, $past(cfg.vsFiltThr)}) + FCNT_W'(1)));

  // R8: the line counter restarts after each line strobe
  p_line_restart_r8: assert property (@(posedge clk) disable iff (!rstN || softReset)
    stb.lineInt |=> (lineCnt == '0));

  // R9: nothing is taken while a full FIFO is sampled with stalling on
  p_stall_drop_r9: assert property (@(posedge clk) disable iff (!rstN || softReset)
    (cfg.stallEn && $past(fifoFull) && !$past(softReset)) |-> !stb.take);

  // R7: after the byte count closes a frame, no second end strobe until a new frame
  p_count_quiet_r7: assert property (@(posedge clk) disable iff (!rstN || softReset)
    (countDone && !cfg.vsEof && !frameStart) |-> !stb.eof);
endmodule

// File: rtl/dvpc_datapath.sv
module dvpc_datapath
  import dvpc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  dvpc_cfg_t        cfg,
  input  dvpc_stb_t        stb,
  input  logic [BUS_W-1:0] pixData,
  output logic             outValid,
  output logic [BUS_W-1:0] outWord,
  output logic             outOneByte,
  output logic             outEof,
  output logic             outLineInt
);
  localparam int NBYTES = BUS_W / BYTE_W;

  logic [BUS_W-1:0]  sData;
  logic [BYTE_W-1:0] pend, nxtPend;
  logic havePend, curHave, nxtHave, emit, one;
  logic [BUS_W-1:0] word;

  function automatic logic [BUS_W-1:0] fmtWord(input logic [BUS_W-1:0] w,
                                                input logic swap, input logic rev);
    logic [BUS_W-1:0] r;
    r = w;
    if (rev) begin
      for (int b = 0; b < NBYTES; b++)
        for (int i = 0; i < BYTE_W; i++)
          r[b*BYTE_W + i] = w[b*BYTE_W + BYTE_W-1-i];
    end
    if (swap) r = {r[BYTE_W-1:0], r[BUS_W-1:BYTE_W]};
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sData <= '0;
    else sData <= pixData;
  end

  always_comb begin
    curHave = stb.clearPend ? 1'b0 : havePend;
    nxtHave = curHave;
    nxtPend = pend;
    emit = 1'b0;
    one = 1'b0;
    word = '0;
    if (stb.take) begin
      if (cfg.wide16) begin
        emit = 1'b1;
        word = sData;
      end else if (curHave) begin
        emit = 1'b1;
        word = {sData[BYTE_W-1:0], pend};
        nxtHave = 1'b0;
      end else begin
        nxtPend = sData[BYTE_W-1:0];
        nxtHave = 1'b1;
      end
    end
    if (stb.eof && nxtHave && !emit) begin
      emit = 1'b1;
      one = 1'b1;
      word = {{(BUS_W-BYTE_W){1'b0}}, nxtPend};
      nxtHave = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0; havePend <= 1'b0;
      outValid <= 1'b0; outWord <= '0; outOneByte <= 1'b0;
      outEof <= 1'b0; outLineInt <= 1'b0;
    end else if (softReset) begin
      pend <= '0; havePend <= 1'b0;
      outValid <= 1'b0; outWord <= '0; outOneByte <= 1'b0;
      outEof <= 1'b0; outLineInt <= 1'b0;
    end else begin
      pend       <= nxtPend;
      havePend   <= nxtHave;
      outValid   <= emit;
      outWord    <= fmtWord(word, cfg.byteSwap, cfg.bitRev);
      outOneByte <= one;
      outEof     <= stb.eof;
      outLineInt <= stb.lineInt;
    end
  end

  // R2: a half word never survives in 16-bit mode
  p_no_pend_wide_r2: assert property (@(posedge clk) disable iff (!rstN || softReset)
    cfg.wide16 |-> !havePend);

  // R6: a single-byte word only appears together with a frame end
  p_lone_byte_eof_r6: assert property (@(posedge clk) disable iff (!rstN || softReset)
    outOneByte |-> (outValid && outEof));
endmodule

// File: rtl/dvp_capture.sv
module dvp_capture
  import dvpc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                cfgUpdate,
  input  logic                softReset,
  input  logic                fifoReset,
  input  logic                cfgWide16,
  input  logic                cfgInvDe,
  input  logic                cfgInvHsync,
  input  logic                cfgInvVsync,
  input  logic                cfgVsFiltEn,
  input  logic [THR_W-1:0]    cfgVsFiltThr,
  input  logic                cfgDeOnly,
  input  logic                cfgVsEof,
  input  logic [CNT_W-1:0]    cfgByteLen,
  input  logic                cfgLineIntEn,
  input  logic [LINE_W-1:0]   cfgLineNum,
  input  logic                cfgStallEn,
  input  logic                cfgByteSwap,
  input  logic                cfgBitRev,
  input  logic [BUS_W-1:0]    pixData,
  input  logic                vsyncIn,
  input  logic                hsyncIn,
  input  logic                deIn,
  input  logic                fifoFull,
  output logic                outValid,
  output logic [BUS_W-1:0]    outWord,
  output logic                outOneByte,
  output logic                outEof,
  output logic                outLineInt
);
  dvpc_cfg_t cfgIn, cfgQ;
  dvpc_stb_t stb;

  always_comb begin
    cfgIn.wide16    = cfgWide16;
    cfgIn.invDe     = cfgInvDe;
    cfgIn.invHs     = cfgInvHsync;
    cfgIn.invVs     = cfgInvVsync;
    cfgIn.vsFiltEn  = cfgVsFiltEn;
    cfgIn.vsFiltThr = cfgVsFiltThr;
    cfgIn.deOnly    = cfgDeOnly;
    cfgIn.vsEof     = cfgVsEof;
    cfgIn.byteLen   = cfgByteLen;
    cfgIn.lineIntEn = cfgLineIntEn;
    cfgIn.lineNum   = cfgLineNum;
    cfgIn.stallEn   = cfgStallEn;
    cfgIn.byteSwap  = cfgByteSwap;
    cfgIn.bitRev    = cfgBitRev;
  end

  dvpc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgUpdate(cfgUpdate),
    .softReset(softReset), .fifoReset(fifoReset), .cfgIn(cfgIn),
    .vsyncIn(vsyncIn), .hsyncIn(hsyncIn), .deIn(deIn), .fifoFull(fifoFull),
    .cfg(cfgQ), .stb(stb)
  );

  dvpc_datapath uData (
    .clk(clk), .rstN(rstN), .softReset(softReset), .cfg(cfgQ), .stb(stb),
    .pixData(pixData), .outValid(outValid), .outWord(outWord),
    .outOneByte(outOneByte), .outEof(outEof), .outLineInt(outLineInt)
  );
endmodule

// File: tb/dvp_capture_test.sv
`timescale 1ns/1ps
module dvp_capture_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, start, cfgUpdate, softReset, fifoReset;
  logic cWide16, cInvDe, cInvHs, cInvVs, cFiltEn, cDeOnly, cVsEof;
  logic cLineIntEn, cStallEn, cSwap, cRev;
  logic [2:0] cThr;
  logic [15:0] cByteLen;
  logic [5:0] cLineNum;
  logic [15:0] pd;
  logic pvs, phs, pde, pfull;
  logic outValid, outOneByte, outEof, outLineInt;
  logic [15:0] outWord;

  int nChecks = 0;
  int nFail = 0;
  int eofN = 0;
  int lineN = 0;
  logic [15:0] wq[$];
  bit oq[$];

  dvp_capture uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgUpdate(cfgUpdate),
    .softReset(softReset), .fifoReset(fifoReset),
    .cfgWide16(cWide16), .cfgInvDe(cInvDe), .cfgInvHsync(cInvHs),
    .cfgInvVsync(cInvVs), .cfgVsFiltEn(cFiltEn), .cfgVsFiltThr(cThr),
    .cfgDeOnly(cDeOnly), .cfgVsEof(cVsEof), .cfgByteLen(cByteLen),
    .cfgLineIntEn(cLineIntEn), .cfgLineNum(cLineNum), .cfgStallEn(cStallEn),
    .cfgByteSwap(cSwap), .cfgBitRev(cRev), .pixData(pd), .vsyncIn(pvs),
    .hsyncIn(phs), .deIn(pde), .fifoFull(pfull), .outValid(outValid),
    .outWord(outWord), .outOneByte(outOneByte), .outEof(outEof),
    .outLineInt(outLineInt)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin wq.push_back(outWord); oq.push_back(outOneByte); end
      if (outEof) eofN++;
      if (outLineInt) lineN++;
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    wq.delete(); oq.delete(); eofN = 0; lineN = 0;
  endtask

  task automatic drv(input logic [15:0] d, input logic de, input logic hs, input logic vs);
    pd = d; pde = de; phs = hs; pvs = vs;
    tick();
  endtask

  task automatic openFrame();
    repeat (3) drv(16'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic closeFrame();
    repeat (5) drv(16'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic applyCfg();
    cfgUpdate = 1'b1; tick();
    cfgUpdate = 1'b0; tick();
  endtask

  task automatic defaultCfg();
    cWide16 = 0; cInvDe = 0; cInvHs = 0; cInvVs = 0; cFiltEn = 0; cThr = 0;
    cDeOnly = 0; cVsEof = 1; cByteLen = 0; cLineIntEn = 0; cLineNum = 0;
    cStallEn = 0; cSwap = 0; cRev = 0;
    applyCfg();
  endtask

  task automatic testReset();
    chk("R1 reset outValid", outValid, 0);
    chk("R6 reset outEof", outEof, 0);
    chk("R8 reset outLineInt", outLineInt, 0);
  endtask

  task automatic testPack8();
    defaultCfg(); clearLog();
    openFrame();
    drv(16'h11, 1, 1, 1); drv(16'h22, 1, 1, 1);
    drv(16'h33, 1, 1, 1); drv(16'h44, 1, 1, 1);
    closeFrame();
    chk("R1 word count", wq.size(), 2);
    if (wq.size() == 2) begin
      chk("R1 word0", wq[0], 16'h2211);
      chk("R1 word1", wq[1], 16'h4433);
    end
    chk("R6 eof count", eofN, 1);
  endtask

  task automatic testFlush();
    defaultCfg(); clearLog();
    openFrame();
    drv(16'hAA, 1, 1, 1); drv(16'hBB, 1, 1, 1); drv(16'hCC, 1, 1, 1);
    closeFrame();
    chk("R6 word count", wq.size(), 2);
    if (wq.size() == 2) begin
      chk("R6 full word", wq[1-1], 16'hBBAA);
      chk("R6 lone byte", wq[1], 16'h00CC);
      chk("R6 lone flag", oq[1], 1);
    end
    chk("R6 eof", eofN, 1);
  endtask

  task automatic testWide();
    defaultCfg(); cWide16 = 1; applyCfg(); clearLog();
    openFrame();
    drv(16'h1234, 1, 1, 1); drv(16'h5678, 1, 1, 1);
    closeFrame();
    chk("R2 word count", wq.size(), 2);
    if (wq.size() == 2) begin
      chk("R2 word0", wq[0], 16'h1234);
      chk("R2 word1", wq[1], 16'h5678);
    end
  endtask

  task automatic testModes();
    defaultCfg(); clearLog();
    openFrame();
    drv(16'hA1, 1, 1, 1); drv(16'hA2, 1, 0, 1); drv(16'hA3, 1, 1, 1);
    closeFrame();
    chk("R4 full mode words", wq.size(), 1);
    if (wq.size() == 1) chk("R4 full mode drops hs low", wq[0], 16'hA3A1);
    cDeOnly = 1; applyCfg(); clearLog();
    openFrame();
    drv(16'hA1, 1, 1, 1); drv(16'hA2, 1, 0, 1); drv(16'hA3, 1, 1, 1);
    closeFrame();
    chk("R4 de-only words", wq.size(), 2);
    if (wq.size() == 2) begin
      chk("R4 de-only ignores hs", wq[0], 16'hA2A1);
      chk("R4 de-only flush", wq[1], 16'h00A3);
    end
  endtask

  task automatic testInvert();
    defaultCfg();
    pvs = 1; phs = 1; pde = 1;
    cInvDe = 1; cInvHs = 1; cInvVs = 1; applyCfg();
    repeat (2) drv(16'h0, 1, 1, 1);
    clearLog();
    repeat (3) drv(16'h0, 1, 1, 0);
    drv(16'h5A, 0, 0, 0); drv(16'h6B, 0, 0, 0);
    repeat (5) drv(16'h0, 1, 1, 1);
    chk("R3 inverted words", wq.size(), 1);
    if (wq.size() == 1) chk("R3 inverted data", wq[0], 16'h6B5A);
    chk("R3 inverted eof", eofN, 1);
    cInvDe = 0; cInvHs = 0; cInvVs = 0; applyCfg();
    closeFrame();
  endtask

  task automatic testFormat();
    defaultCfg(); cWide16 = 1; cSwap = 1; applyCfg(); clearLog();
    openFrame(); drv(16'h1201, 1, 1, 1); closeFrame();
    if (wq.size() == 1) chk("R10 swap", wq[0], 16'h0112); else chk("R10 swap count", wq.size(), 1);
    cSwap = 0; cRev = 1; applyCfg(); clearLog();
    openFrame(); drv(16'h1201, 1, 1, 1); closeFrame();
    if (wq.size() == 1) chk("R10 bit reverse", wq[0], 16'h4880); else chk("R10 rev count", wq.size(), 1);
    cSwap = 1; applyCfg(); clearLog();
    openFrame(); drv(16'h1201, 1, 1, 1); closeFrame();
    if (wq.size() == 1) chk("R10 swap and reverse", wq[0], 16'h8048); else chk("R10 both count", wq.size(), 1);
  endtask

  task automatic testByteCount();
    defaultCfg(); cVsEof = 0; cByteLen = 16'd3; applyCfg(); clearLog();
    openFrame();
    drv(16'hB0, 1, 1, 1); drv(16'hB1, 1, 1, 1); drv(16'hB2, 1, 1, 1);
    drv(16'hB3, 1, 1, 1); drv(16'hB4, 1, 1, 1);
    closeFrame();
    chk("R7 words", wq.size(), 2);
    if (wq.size() == 2) begin
      chk("R7 first word", wq[0], 16'hB1B0);
      chk("R7 last byte flushed", wq[1], 16'h00B2);
      chk("R7 lone flag", oq[1], 1);
    end
    chk("R7 single eof, sync fall ignored", eofN, 1);
  endtask

  task automatic testLines();
    defaultCfg(); cLineIntEn = 1; cLineNum = 6'd2; applyCfg(); clearLog();
    openFrame();
    for (int i = 0; i < 5; i++) begin
      drv(16'h1, 1, 1, 1); drv(16'h0, 0, 0, 1);
    end
    closeFrame();
    chk("R8 two strobes in five lines", lineN, 2);
    for (int f = 0; f < 2; f++) begin
      openFrame(); drv(16'h1, 1, 1, 1); drv(16'h0, 0, 0, 1); closeFrame();
    end
    chk("R8 count restarts per frame", lineN, 2);
  endtask

  task automatic testStall();
    defaultCfg(); cStallEn = 1; applyCfg(); clearLog();
    openFrame();
    pfull = 0; drv(16'h01, 1, 1, 1);
    pfull = 1; drv(16'h02, 1, 1, 1);
    pfull = 0; drv(16'h03, 1, 1, 1); drv(16'h04, 1, 1, 1); drv(16'h05, 1, 1, 1);
    closeFrame();
    chk("R9 stall words", wq.size(), 2);
    if (wq.size() == 2) begin
      chk("R9 stalled byte dropped", wq[0], 16'h0301);
      chk("R9 following word", wq[1], 16'h0504);
    end
    cStallEn = 0; applyCfg(); clearLog();
    pfull = 1; openFrame();
    drv(16'h61, 1, 1, 1); drv(16'h62, 1, 1, 1);
    closeFrame(); pfull = 0;
    if (wq.size() == 1) chk("R9 full ignored when off", wq[0], 16'h6261);
    else chk("R9 off count", wq.size(), 1);
  endtask

  task automatic testShadow();
    defaultCfg(); cWide16 = 1; clearLog();
    openFrame(); drv(16'hAB12, 1, 1, 1); drv(16'hCD34, 1, 1, 1); closeFrame();
    if (wq.size() == 1) chk("R11 width unchanged without update", wq[0], 16'h3412);
    else chk("R11 shadow count", wq.size(), 1);
    cWide16 = 0;
    start = 0; tick(); clearLog();
    openFrame(); drv(16'h77, 1, 1, 1); drv(16'h88, 1, 1, 1); closeFrame();
    chk("R11 nothing taken while stopped", wq.size(), 0);
    start = 1; tick();
  endtask

  task automatic testFilter();
    defaultCfg(); cFiltEn = 1; cThr = 3'd2; applyCfg(); clearLog();
    repeat (6) drv(16'h0, 0, 0, 1);
    repeat (3) drv(16'h0, 0, 0, 0);
    repeat (6) drv(16'h0, 0, 0, 1);
    chk("R5 short glitch rejected", eofN, 0);
    repeat (4) drv(16'h0, 0, 0, 0);
    repeat (6) drv(16'h0, 0, 0, 1);
    chk("R5 held low accepted", eofN, 1);
    repeat (6) drv(16'h0, 0, 0, 0);
    cFiltEn = 0; applyCfg(); clearLog();
    repeat (3) drv(16'h0, 0, 0, 1);
    drv(16'h0, 0, 0, 0);
    repeat (3) drv(16'h0, 0, 0, 1);
    chk("R5 bypass uses raw pin", eofN, 1);
    closeFrame();
  endtask

  task automatic testFifoReset();
    defaultCfg(); clearLog();
    openFrame();
    drv(16'h55, 1, 1, 1);
    drv(16'h0, 0, 1, 1);
    fifoReset = 1; drv(16'h0, 0, 1, 1); fifoReset = 0;
    drv(16'h66, 1, 1, 1); drv(16'h77, 1, 1, 1);
    closeFrame();
    chk("R12 words after reset", wq.size(), 1);
    if (wq.size() == 1) chk("R12 pending byte dropped", wq[0], 16'h7766);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rstN = 0; start = 1; cfgUpdate = 0; softReset = 0; fifoReset = 0;
    cWide16 = 0; cInvDe = 0; cInvHs = 0; cInvVs = 0; cFiltEn = 0; cThr = 0;
    cDeOnly = 0; cVsEof = 1; cByteLen = 0; cLineIntEn = 0; cLineNum = 0;
    cStallEn = 0; cSwap = 0; cRev = 0;
    pd = 0; pvs = 0; phs = 0; pde = 0; pfull = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testPack8();
    testFlush();
    testWide();
    testModes();
    testInvert();
    testFormat();
    testByteCount();
    testLines();
    testStall();
    testShadow();
    testFilter();
    testFifoReset();
    summary();
  end
endmodule